// File: doc/BRIEF.md
# SHA-224/256 Iterative Round Compression Engine

This block performs the compression step of the SHA-224 and SHA-256 hash functions on one 512-bit block at a time. It does not pad the message or expand it: an upstream stage delivers the 64 scheduled 32-bit words, one per round, over a simple valid/ready stream. Each accepted word drives one round of the eight working variables. The 64 rounds depend on each other, so exactly one round is evaluated per accepted word. The 64 round constants come from an internal ROM.

A block is opened with a start pulse. A first-block flag picks the chaining value. If the flag is set, the engine loads the standard initial vector of the selected variant. If it is clear, the engine continues from the digest of the previous block, so long messages are handled by chaining blocks. After the 64th word the working variables are folded into the chaining hash, a one-cycle done pulse is raised, and the digest stays on the output until the next block starts. In SHA-224 mode the output carries the first seven hash words and zero-fills the rest.

While the engine waits for a start or for the next word, every register holds its value through a synchronous enable. This enable stands in for a gated clock on the register bank.

Top module: `sha2_round_core`

## Requirements
- R1: Each word accepted (w_valid high while w_ready is high) applies one standard SHA-2 round to the working variables with the round constant of the current round index. After 64 accepted words, the block's digest equals the standard SHA-256/SHA-224 compression result.
- R2: A start accepted with first_blk=1 loads the chaining hash and the working variables with the standard initial vector of the variant chosen by mode_224 (0 = SHA-256, 1 = SHA-224).
- R3: A start accepted with first_blk=0 loads the working variables from the current chaining hash, which is the full eight-word result of the previous block.
- R4: In the clock edge that accepts the 64th word, each chaining word gets its working variable added modulo 2^32. done is high for exactly the one cycle that follows that edge.
- R5: digest carries hash word 0 in bits 255:224 down to word 7 in bits 31:0. When the block was started with mode_224=1, bits 31:0 read zero and bits 255:32 hold words 0 to 6.
- R6: From the done pulse until the next accepted start, digest does not change.
- R7: While w_ready is high and w_valid is low, the round index and all working variables hold their values and w_data is ignored.
- R8: start is ignored while w_ready is high. w_valid and w_data are ignored while w_ready is low.
- R9: After reset, done and w_ready are low. w_ready rises in the cycle after an accepted start and falls in the cycle after the 64th word is accepted.
- R10: The variant is latched when start is accepted. A change of mode_224 during a block has no effect on that block's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new block when the engine is idle |
| first_blk | input | 1 | With start: 1 loads the initial vector, 0 chains from the previous digest |
| mode_224 | input | 1 | With start: 1 selects SHA-224, 0 selects SHA-256 |
| w_valid | input | 1 | A scheduled word is present on w_data |
| w_data | input | 32 | Scheduled message word for the current round |
| w_ready | output | 1 | Engine is inside a block and accepts words |
| done | output | 1 | One-cycle pulse: the digest has been updated |
| digest | output | 256 | Chaining hash, truncated and zero-filled in SHA-224 mode |

## Verification
The embedded assertions check the control behaviour on every cycle. They confirm that a stalled round leaves the index and the working variables frozen, that done lasts a single cycle, that an accepted start opens a block at round zero, that the latched variant stays put during a block, and that the digest stays still while the engine is idle. The arithmetic itself cannot be seen by a property. Only the bench's scenarios show it: known-answer blocks for both variants, chained random blocks checked against a model written separately, and random stalls, with stray starts and variant changes injected mid-block.

// File: rtl/sha2_pkg.sv
package sha2_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 8;
  localparam int ROUNDS = 64;
  localparam int RND_W  = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } vars_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sum_a(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t sum_e(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t choose(input word_t x, y, z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(input word_t x, y, z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic vars_t add_vars(input vars_t p, q);
    vars_t r;
    r.a = p.a + q.a; r.b = p.b + q.b; r.c = p.c + q.c; r.d = p.d + q.d;
    r.e = p.e + q.e; r.f = p.f + q.f; r.g = p.g + q.g; r.h = p.h + q.h;
    return r;
  endfunction

  function automatic vars_t init_vector(input logic m224);
    if (m224)
      return '{32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
               32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
    else
      return '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
               32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  endfunction
endpackage

// File: rtl/sha2_krom.sv
module sha2_krom
  import sha2_pkg::*;
(
  input  logic [RND_W-1:0] idx,
  output word_t            k
);
  always_comb begin
    case (idx)
      6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491; 6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1; 6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01; 6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe; 6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786; 6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa; 6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d; 6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147; 6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138; 6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb; 6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b; 6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624; 6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08; 6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a; 6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f; 6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb; 6'd62: k = 32'hbef9a3f7; default: k = 32'hc67178f2;
    endcase
  end
endmodule

// File: rtl/sha2_round.sv
module sha2_round
  import sha2_pkg::*;
(
  input  vars_t cur,
  input  word_t k,
  input  word_t w,
  output vars_t nxt
);
  word_t t1, t2;

  always_comb begin
    t1 = cur.h + sum_e(cur.e) + choose(cur.e, cur.f, cur.g) + k + w;
    t2 = sum_a(cur.a) + majority(cur.a, cur.b, cur.c);
    nxt.a = t1 + t2;
    nxt.b = cur.a;
    nxt.c = cur.b;
    nxt.d = cur.c;
    nxt.e = cur.d + t1;
    nxt.f = cur.e;
    nxt.g = cur.f;
    nxt.h = cur.g;
  end
endmodule

// File: rtl/sha2_ctrl.sv
module sha2_ctrl
  import sha2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             w_valid,
  output logic             busy,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic             done,
  output logic [RND_W-1:0] rnd
);
  assign load = start & ~busy;
  assign step = busy & w_valid;
  assign last = step & (rnd == RND_W'(ROUNDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy <= 1'b1;
        rnd  <= '0;
      end else if (step) begin
        rnd <= rnd + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !w_valid |=> busy && $stable(rnd));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done && !busy);
  // R9
  open_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && rnd == '0);
endmodule

// File: rtl/sha2_round_core.sv
module sha2_round_core
  import sha2_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         first_blk,
  input  logic         mode_224,
  input  logic         w_valid,
  input  logic [31:0]  w_data,
  output logic         w_ready,
  output logic         done,
  output logic [255:0] digest
);
  logic             busy, load, step, last, reg_en;
  logic [RND_W-1:0] rnd;
  word_t            k_cur;
  vars_t            work_q, work_nxt, hash_q;
  logic             mode_q;

  sha2_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .w_valid(w_valid),
    .busy(busy), .load(load), .step(step), .last(last), .done(done), .rnd(rnd)
  );

  sha2_krom u_krom (.idx(rnd), .k(k_cur));

  sha2_round u_round (.cur(work_q), .k(k_cur), .w(w_data), .nxt(work_nxt));

  // Register-bank enable: stands in for a gated clock while idle or stalled
  assign reg_en = load | step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q <= '0;
      hash_q <= '0;
      mode_q <= 1'b0;
    end else if (reg_en) begin
      if (load) begin
        mode_q <= mode_224;
        if (first_blk) begin
          hash_q <= init_vector(mode_224);
          work_q <= init_vector(mode_224);
        end else begin
          work_q <= hash_q;
        end
      end else begin
        work_q <= work_nxt;
        if (last) hash_q <= add_vars(hash_q, work_nxt);
      end
    end
  end

  assign w_ready = busy;
  assign digest  = mode_q ? {hash_q[255:32], 32'h0} : hash_q;

  // R7
  vars_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_ready && !w_valid |=> $stable(work_q));
  // R6
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !w_ready && !start |=> $stable(digest));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_ready |=> $stable(mode_q));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_ready && !w_valid && start |=> w_ready && $stable(hash_q));
endmodule

// File: tb/sha2_round_core_tb.sv
module sha2_round_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, first_blk = 1'b0, mode_224 = 1'b0, w_valid = 1'b0;
  logic [31:0]  w_data = '0;
  logic         w_ready, done;
  logic [255:0] digest;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0]  wq [64];
  logic [255:0] model_h = '0;

  logic [31:0] kb [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  sha2_round_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk), .mode_224(mode_224),
    .w_valid(w_valid), .w_data(w_data), .w_ready(w_ready), .done(done), .digest(digest)
  );

  always #5 clk = ~clk;

  // Bench-side arithmetic, written with explicit rotates by shifting
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [255:0] iv_of(input bit m);
    return m ? 256'hc1059ed8_367cd507_3070dd17_f70e5939_ffc00b31_68581511_64f98fa7_befa4fa4
             : 256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
  endfunction

  function automatic logic [255:0] ref_compress(input logic [255:0] hin);
    logic [31:0] v [8];
    logic [31:0] x, y;
    logic [255:0] r;
    for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      x = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) + ((v[4] & v[5]) | (~v[4] & v[6])) + kb[t] + wq[t];
      y = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) + ((v[0] & v[1]) | (v[2] & (v[0] | v[1])));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + x;
      v[0] = x + y;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = hin[255-32*i -: 32] + v[i];
    return r;
  endfunction

  function automatic logic [255:0] shown(input logic [255:0] h, input bit m);
    return m ? {h[255:32], 32'h0} : h;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_abc();
    for (int t = 0; t < 64; t++) wq[t] = '0;
    wq[0] = 32'h61626380;
    wq[15] = 32'h00000018;
    for (int t = 16; t < 64; t++)
      wq[t] = (rr(wq[t-2],17) ^ rr(wq[t-2],19) ^ (wq[t-2] >> 10)) + wq[t-7]
            + (rr(wq[t-15],7) ^ rr(wq[t-15],18) ^ (wq[t-15] >> 3)) + wq[t-16];
  endtask

  task automatic load_rand();
    for (int t = 0; t < 64; t++) wq[t] = $urandom;
  endtask

  // Runs one block; gaps add stalls with garbage data, poke drives stray start/mode during stalls
  task automatic run_block(input bit fb, input bit m, input int gap_pct, input bit poke);
    @(negedge clk);
    start = 1'b1; first_blk = fb; mode_224 = m;
    @(negedge clk);
    start = 1'b0;
    chk("R9 ready after start", {255'h0, w_ready}, 256'h1);
    for (int t = 0; t < 64; t++) begin
      while (int'($urandom % 100) < gap_pct) begin
        w_valid = 1'b0; w_data = $urandom;
        if (poke) begin start = 1'b1; first_blk = 1'b1; mode_224 = ~m; end
        @(negedge clk);
        start = 1'b0; mode_224 = m;
      end
      w_valid = 1'b1; w_data = wq[t];
      if (poke && t == 30) mode_224 = ~m;
      @(negedge clk);
      mode_224 = m;
    end
    w_valid = 1'b0;
    model_h = ref_compress(fb ? iv_of(m) : model_h);
    chk("R4 done after last word", {254'h0, done, w_ready}, 256'h2);
    chk("R1 R5 digest", digest, shown(model_h, m));
    // idle with stray words: must be ignored and digest held
    for (int i = 0; i < 3; i++) begin
      w_valid = 1'b1; w_data = $urandom;
      @(negedge clk);
      chk("R4 R8 done low, not ready", {254'h0, done, w_ready}, 256'h0);
      chk("R6 R8 digest held", digest, shown(model_h, m));
    end
    w_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset outputs", {254'h0, done, w_ready}, 256'h0);

    // R1 R2 R5: known answers for the three-byte message "abc"
    load_abc();
    run_block(1'b1, 1'b0, 0, 1'b0);
    chk("R1 R2 sha256 known answer", digest,
        256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad);
    run_block(1'b1, 1'b1, 30, 1'b0);
    // R7 stalls, R5 truncation
    chk("R2 R5 R7 sha224 known answer", digest,
        {224'h23097d22_3405d822_8642a477_bda255b3_2aadbce4_bda0b3f7_e36c9da7, 32'h0});

    // R3 chaining; R8 R10 stray start and mode changes mid-block
    load_rand(); run_block(1'b1, 1'b0, 20, 1'b1);
    load_rand(); run_block(1'b0, 1'b0, 20, 1'b1);
    load_rand(); run_block(1'b1, 1'b1, 25, 1'b1);
    load_rand(); run_block(1'b0, 1'b1, 10, 1'b0);
    load_rand(); run_block(1'b0, 1'b1, 40, 1'b1);

    // random mixes
    for (int b = 0; b < 6; b++) begin
      load_rand();
      run_block(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 35), bit'($urandom % 2));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule